// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is a synthesizable model of a synchronous SRAM whose read data and write data both trail their command by two clock cycles. Because both directions share this fixed offset, a controller can issue a read on one cycle and a write on the next (or the reverse) without leaving an idle cycle on the shared data bus. The bus is bidirectional. It is driven from an output register, and an asynchronous active-low output enable can float it at any time. Incoming write data is captured into an input register before it reaches the array.

Each command is either a load or an advance. A load starts a four-beat burst at an external address. An advance steps the burst counter and keeps the direction that the load chose. The low two address bits follow a linear or an interleaved order, picked by a static mode input. Each 9-bit byte lane has its own active-low write strobe. An active-low clock enable freezes every register, which has the same effect as removing a clock edge. A read that closely follows a write to the same word returns the new bytes, because it is forwarded from the write stages that have not yet reached the array.

Top module: `turnless_sram`

## Requirements
- R1: The chip is selected when selN=0 and selP=1. A selected load (loadN=0) with writeN=1, sampled at enabled edge N, drives the addressed word onto `data` during the cycle between enabled edges N+1 and N+2. The word reflects every write commanded before the read.
- R2: Lane i is bits [9i+8:9i]. In a write beat sampled at enabled edge N, lane i is updated only if byteWrN[i]=0 at edge N. Its new value is taken from `data` as sampled at enabled edge N+2.
- R3: On a read beat, byteWrN has no effect: the stored word is unchanged.
- R4: A selected load sets burst beat 0 at `addr`. Each advance (loadN=1) moves to the next beat k=1,2,3, then wraps to 0. The upper address bits stay fixed. The low two bits are (base+k) mod 4 when interleave=0, and base XOR k when interleave=1.
- R5: Advance beats keep the direction of the load that started the burst. writeN is ignored on advances, while byteWrN is sampled on every write beat.
- R6: In the cycle between edges N+1 and N+2, the block does not drive `data` if the command at N was a write, a deselecting load, or an advance with no burst open. A deselecting load ends the burst, so later advances do nothing.
- R7: While outEnN=1, `data` floats immediately, whatever the pipeline holds. Clearing it restores the pending read word within the same cycle.
- R8: An edge with clkEnN=1 changes no state. The bus keeps its value and drive, and all other inputs are ignored.
- R9: A read issued one or two enabled cycles after a write to the same word returns the newly written lanes, merged with the older contents of the unwritten lanes.
- R10: While rstN=0, and after it is released, `data` is not driven until a read reaches its data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the pipeline control |
| clkEnN | input | 1 | Active-low clock enable; high freezes the block |
| selN | input | 1 | Active-low chip select |
| selP | input | 1 | Active-high chip select |
| loadN | input | 1 | Low loads a new command, high advances the burst |
| writeN | input | 1 | Low selects write, high selects read, on a load |
| byteWrN | input | 2 | Active-low write strobe per 9-bit lane |
| addr | input | 6 | Word address, sampled on loads |
| interleave | input | 1 | Static burst order: 1 interleaved, 0 linear |
| outEnN | input | 1 | Asynchronous active-low output enable |
| data | inout | 18 | Shared registered data bus |

## Verification
A corrupted burst counter or command stage shows up as a wrong word, or a missing drive, in the very next data cycle, two enabled edges after the faulty beat. A broken forwarding path or lane mask stays hidden until the word is read back. The stimulus therefore places reads one and two cycles behind writes to the same word, so that such faults appear within three cycles. A stall that leaks through shows up as bus data shifted by one slot. The same happens when a write-data register does not hold during a stall.

// File: rtl/turnless_pkg.sv
package turnless_pkg;
  parameter int ADDR_W = 6;
  parameter int LANES  = 2;
  parameter int LANE_W = 9;
  parameter int BEAT_W = 2;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  // strobes from control to datapath for one enabled edge
  typedef struct packed {
    logic              step;     // clock enable active
    logic              rdEn;     // read beat in first stage
    logic [ADDR_W-1:0] rdAddr;
    logic              capEn;    // write beat whose bus data is present now
    logic [ADDR_W-1:0] capAddr;
    logic [LANES-1:0]  capBe;
  } strobe_t;
endpackage

// File: rtl/turnless_ctrl.sv
module turnless_ctrl
  import turnless_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              selN,
  input  logic              selP,
  input  logic              loadN,
  input  logic              writeN,
  input  logic [LANES-1:0]  byteWrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              interleave,
  output strobe_t           strb
);
  typedef struct packed {
    logic              valid;
    logic              write;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  be;
  } cmd_t;

  logic step, chipOn;
  logic burstOn, burstWr, burstOnNx, burstWrNx;
  logic [ADDR_W-1:0] baseAddr, baseNx;
  logic [BEAT_W-1:0] beatCnt, beatNx, seqLow;
  cmd_t cmdNow, stage1, stage2;

  assign step   = !clkEnN;
  assign chipOn = !selN && selP;

  // decode this edge's beat and the next burst state
  always_comb begin
    burstOnNx = burstOn;
    burstWrNx = burstWr;
    baseNx    = baseAddr;
    beatNx    = beatCnt;
    seqLow    = '0;
    cmdNow    = '0;
    if (!loadN) begin
      burstOnNx = chipOn;
      burstWrNx = !writeN;
      baseNx    = addr;
      beatNx    = '0;
      if (chipOn) begin
        cmdNow.valid = 1'b1;
        cmdNow.write = !writeN;
        cmdNow.addr  = addr;
      end
    end else if (burstOn) begin
      beatNx = beatCnt + 1'b1;
      seqLow = interleave ? (baseAddr[BEAT_W-1:0] ^ beatNx)
                          : (baseAddr[BEAT_W-1:0] + beatNx);
      cmdNow.valid = 1'b1;
      cmdNow.write = burstWr;
      cmdNow.addr  = {baseAddr[ADDR_W-1:BEAT_W], seqLow};
    end
    if (cmdNow.write) cmdNow.be = ~byteWrN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstOn <= 1'b0;
      burstWr <= 1'b0;
      baseAddr <= '0;
      beatCnt <= '0;
      stage1 <= '0;
      stage2 <= '0;
    end else if (step) begin
      burstOn <= burstOnNx;
      burstWr <= burstWrNx;
      baseAddr <= baseNx;
      beatCnt <= beatNx;
      stage1 <= cmdNow;
      stage2 <= stage1;
    end
  end

  assign strb.step    = step;
  assign strb.rdEn    = stage1.valid && !stage1.write;
  assign strb.rdAddr  = stage1.addr;
  assign strb.capEn   = stage2.valid && stage2.write;
  assign strb.capAddr = stage2.addr;
  assign strb.capBe   = stage2.be;
endmodule

// File: rtl/turnless_datapath.sv
module turnless_datapath
  import turnless_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busIn,
  output logic              driveQ,
  output logic [DATA_W-1:0] outQ
);
  logic              wrValid;
  logic [ADDR_W-1:0] wrAddr;
  logic [LANES-1:0]  wrBe;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] fwdWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrValid <= 1'b0;
      driveQ  <= 1'b0;
    end else if (strb.step) begin
      wrValid <= strb.capEn;
      driveQ  <= strb.rdEn;
    end
  end

  // input register and output register
  always_ff @(posedge clk) begin
    if (strb.step) begin
      wrAddr <= strb.capAddr;
      wrBe   <= strb.capBe;
      wrData <= busIn;
      if (strb.rdEn) outQ <= fwdWord;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] store [DEPTH];
    logic hitBus, hitReg;

    always_ff @(posedge clk) begin
      if (strb.step && wrValid && wrBe[g])
        store[wrAddr] <= wrData[g*LANE_W +: LANE_W];
    end

    // newest pending write wins: bus stage, then input register, then array
    assign hitBus = strb.capEn && strb.capBe[g] && (strb.capAddr == strb.rdAddr);
    assign hitReg = wrValid && wrBe[g] && (wrAddr == strb.rdAddr);
    assign fwdWord[g*LANE_W +: LANE_W] =
        hitBus ? busIn[g*LANE_W +: LANE_W] :
        hitReg ? wrData[g*LANE_W +: LANE_W] :
                 store[strb.rdAddr];
  end
endmodule

// File: rtl/turnless_sram.sv
module turnless_sram
  import turnless_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              selN,
  input  logic              selP,
  input  logic              loadN,
  input  logic              writeN,
  input  logic [LANES-1:0]  byteWrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              interleave,
  input  logic              outEnN,
  inout  wire  [DATA_W-1:0] data
);
  strobe_t           strb;
  logic              driveQ;
  logic [DATA_W-1:0] outQ;

  turnless_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .selN(selN), .selP(selP),
    .loadN(loadN), .writeN(writeN), .byteWrN(byteWrN), .addr(addr),
    .interleave(interleave), .strb(strb)
  );

  turnless_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busIn(data),
    .driveQ(driveQ), .outQ(outQ)
  );

  assign data = (driveQ && !outEnN) ? outQ : {DATA_W{1'bz}};
endmodule

// File: rtl/turnless_sram_chk.sv
module turnless_sram_chk
  import turnless_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              selN,
  input logic              selP,
  input logic              loadN,
  input logic              writeN,
  input logic              driveQ,
  input logic [DATA_W-1:0] outQ
);
  logic issueLoad, readCmd, writeCmd, deselCmd;
  assign issueLoad = rstN && !clkEnN && !loadN;
  assign readCmd   = issueLoad && !selN && selP && writeN;
  assign writeCmd  = issueLoad && !selN && selP && !writeN;
  assign deselCmd  = issueLoad && !(!selN && selP);

  // R1: a read load leads to drive after the next enabled edge
  assert_read_drives_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(readCmd, 2) && $past(rstN && !clkEnN)) |-> driveQ);

  // R6: a write load leaves the bus undriven in its data cycle
  assert_write_floats_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(writeCmd, 2) && $past(rstN && !clkEnN)) |-> !driveQ);

  // R6: a deselecting load floats the bus in its data cycle
  assert_desel_floats_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(deselCmd, 2) && $past(rstN && !clkEnN)) |-> !driveQ);

  // R8: a stalled edge keeps drive and output register unchanged
  assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(clkEnN)) |-> ($stable(driveQ) && $stable(outQ)));

  // R10: reset removes drive
  assert_reset_quiet_R10: assert property (@(posedge clk)
    $past(!rstN) |-> !driveQ);
endmodule

bind turnless_sram turnless_sram_chk u_chk (.*);

// File: tb/tb_turnless_sram.sv
module tb_turnless_sram;
  import turnless_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, clkEnN, selN, selP, loadN, writeN, interleave, outEnN;
  logic [LANES-1:0]  byteWrN;
  logic [ADDR_W-1:0] addr;
  tri1  [DATA_W-1:0] data;
  logic tbDrive;
  logic [DATA_W-1:0] tbData;
  assign data = tbDrive ? tbData : {DATA_W{1'bz}};

  turnless_sram dut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .selN(selN), .selP(selP),
    .loadN(loadN), .writeN(writeN), .byteWrN(byteWrN), .addr(addr),
    .interleave(interleave), .outEnN(outEnN), .data(data)
  );

  localparam logic [DATA_W-1:0] FLOAT = '1;

  int total = 0;
  int bad = 0;
  logic [DATA_W-1:0] refMem [DEPTH];

  // op history: kind 0 idle, 1 read, 2 write
  int h1Kind, h2Kind;
  logic [ADDR_W-1:0] h1Addr, h2Addr;
  logic [LANES-1:0] h1Be, h2Be;
  string h1Tag, h2Tag;
  bit h1Probe, h2Probe;
  bit newSlot;
  bit bOn, bWr;
  logic [ADDR_W-1:0] bBase;
  logic [BEAT_W-1:0] bCnt;

  function automatic logic [DATA_W-1:0] mixIn(logic [DATA_W-1:0] old,
      logic [DATA_W-1:0] nw, logic [LANES-1:0] be);
    logic [DATA_W-1:0] w = old;
    for (int i = 0; i < LANES; i++)
      if (be[i]) w[i*LANE_W +: LANE_W] = nw[i*LANE_W +: LANE_W];
    return w;
  endfunction

  // never all ones in a lane, so a floating (pulled-up) bus is distinct
  function automatic logic [DATA_W-1:0] freshWord();
    logic [DATA_W-1:0] w;
    for (int i = 0; i < LANES; i++) begin
      logic [LANE_W-1:0] v = LANE_W'($urandom);
      if (v == '1) v[LANE_W-1] = 1'b0;
      w[i*LANE_W +: LANE_W] = v;
    end
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] beatAddr(logic [ADDR_W-1:0] base,
      logic [BEAT_W-1:0] k, logic il);
    logic [BEAT_W-1:0] lo = il ? (base[BEAT_W-1:0] ^ k) : (base[BEAT_W-1:0] + k);
    return {base[ADDR_W-1:BEAT_W], lo};
  endfunction

  task automatic check(bit ok, string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // examine or feed the data cycle of the op two enabled edges back
  task automatic doSlot();
    if (h2Kind == 1) begin
      if (h2Probe) begin
        outEnN = 1'b1; #1;
        check(data === FLOAT, "R7", data, FLOAT);
        outEnN = 1'b0; #1;
      end
      check(data === refMem[h2Addr], h2Tag, data, refMem[h2Addr]);
    end else begin
      check(data === FLOAT, "R6", data, FLOAT);
      if (h2Kind == 2) begin
        if (newSlot) begin
          tbData = freshWord();
          refMem[h2Addr] = mixIn(refMem[h2Addr], tbData, h2Be);
        end
        tbDrive = 1'b1;
      end
    end
  endtask

  task automatic step(bit en, bit ld, bit sel, bit wr, logic [LANES-1:0] bwn,
      logic [ADDR_W-1:0] a, string tag, bit probe = 1'b0);
    int nKind;
    logic [ADDR_W-1:0] nAddr;
    logic [LANES-1:0] nBe;
    doSlot();
    clkEnN = !en; loadN = !ld; writeN = !wr; byteWrN = bwn; addr = a;
    if (sel) begin
      selN = 1'b0; selP = 1'b1;
    end else begin
      case ($urandom % 3)
        0: begin selN = 1'b1; selP = 1'b1; end
        1: begin selN = 1'b0; selP = 1'b0; end
        default: begin selN = 1'b1; selP = 1'b0; end
      endcase
    end
    newSlot = en;
    if (en) begin
      nKind = 0; nAddr = '0; nBe = '0;
      if (ld) begin
        bOn = sel; bWr = wr; bBase = a; bCnt = '0;
        if (sel) begin nKind = wr ? 2 : 1; nAddr = a; end
      end else if (bOn) begin
        bCnt = bCnt + 1'b1;
        nKind = bWr ? 2 : 1;
        nAddr = beatAddr(bBase, bCnt, interleave);
      end
      if (nKind == 2) nBe = ~bwn;
      h2Kind = h1Kind; h2Addr = h1Addr; h2Be = h1Be; h2Tag = h1Tag; h2Probe = h1Probe;
      h1Kind = nKind; h1Addr = nAddr; h1Be = nBe; h1Tag = tag; h1Probe = probe;
    end
    @(posedge clk);
    #1 tbDrive = 1'b0;
    @(negedge clk);
  endtask

  task automatic stall(string tag);
    step(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), LANES'($urandom),
         ADDR_W'($urandom), tag);
  endtask

  task automatic idle2();
    step(1'b1, 1'b1, 1'b0, 1'b0, '1, '0, "R6");
    step(1'b1, 1'b1, 1'b0, 1'b0, '1, '0, "R6");
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0; clkEnN = 1'b0; loadN = 1'b0; selN = 1'b1; selP = 1'b0;
    writeN = 1'b1; byteWrN = '1; addr = '0; interleave = 1'b0; outEnN = 1'b0;
    tbDrive = 1'b0; tbData = '0; newSlot = 1'b1;
    h1Kind = 0; h2Kind = 0; h1Addr = '0; h2Addr = '0; h1Be = '0; h2Be = '0;
    h1Tag = "R6"; h2Tag = "R6"; h1Probe = 1'b0; h2Probe = 1'b0;
    bOn = 1'b0; bWr = 1'b0; bBase = '0; bCnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(data === FLOAT, "R10", data, FLOAT);
    rstN = 1'b1;
    @(negedge clk);
    check(data === FLOAT, "R10", data, FLOAT);

    // fill every word with full-lane writes
    for (int a = 0; a < DEPTH; a++) step(1'b1, 1'b1, 1'b1, 1'b1, '0, ADDR_W'(a), "R2");
    idle2();

    // R2: single-lane writes, read back after the pipeline drains
    step(1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 6'd5, "R2");
    step(1'b1, 1'b1, 1'b1, 1'b1, 2'b01, 6'd6, "R2");
    idle2(); idle2();
    step(1'b1, 1'b1, 1'b1, 1'b0, '1, 6'd5, "R2");
    step(1'b1, 1'b1, 1'b1, 1'b0, '1, 6'd6, "R2");
    idle2();

    // R3: read with all strobes asserted leaves the word alone
    step(1'b1, 1'b1, 1'b1, 1'b0, '0, 6'd7, "R3");
    idle2();
    step(1'b1, 1'b1, 1'b1, 1'b0, '1, 6'd7, "R3");
    idle2();

    // R9: reads one and two cycles behind writes to the same word
    step(1'b1, 1'b1, 1'b1, 1'b1, '0, 6'd9, "R9");
    step(1'b1, 1'b1, 1'b1, 1'b0, '1, 6'd9, "R9");
    step(1'b1, 1'b1, 1'b1, 1'b1, 2'b01, 6'd10, "R9");
    step(1'b1, 1'b1, 1'b0, 1'b0, '1, 6'd0, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b0, '1, 6'd10, "R9");
    step(1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 6'd11, "R9");
    step(1'b1, 1'b1, 1'b1, 1'b1, '0, 6'd12, "R9");
    step(1'b1, 1'b1, 1'b1, 1'b0, '1, 6'd11, "R9");
    step(1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 6'd11, "R9");
    step(1'b1, 1'b1, 1'b1, 1'b0, '1, 6'd11, "R9");
    idle2();

    // R4/R5 linear burst: write with writeN toggled on advances, then read with wrap
    interleave = 1'b0;
    step(1'b1, 1'b1, 1'b1, 1'b1, '0, 6'd13, "R5");
    for (int k = 0; k < 4; k++)
      step(1'b1, 1'b0, 1'b1, 1'($urandom), LANES'($urandom), ADDR_W'($urandom), "R5");
    step(1'b1, 1'b1, 1'b1, 1'b0, '1, 6'd13, "R4");
    for (int k = 0; k < 5; k++)
      step(1'b1, 1'b0, 1'b1, 1'(k & 1), '0, ADDR_W'($urandom), "R4");
    idle2();

    // R4 interleaved burst
    interleave = 1'b1;
    step(1'b1, 1'b1, 1'b1, 1'b1, '0, 6'd22, "R4");
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b1, 1'b0, '0, 6'd0, "R4");
    step(1'b1, 1'b1, 1'b1, 1'b0, '1, 6'd22, "R4");
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b1, 1'b1, '1, 6'd0, "R4");
    idle2();

    // R6: deselect ends a burst, advances then stay idle
    step(1'b1, 1'b1, 1'b1, 1'b0, '1, 6'd30, "R6");
    step(1'b1, 1'b1, 1'b0, 1'b0, '1, 6'd30, "R6");
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b1, 1'b1, '0, 6'd0, "R6");
    idle2();
    step(1'b1, 1'b1, 1'b1, 1'b0, '1, 6'd30, "R6");
    idle2();

    // R7: output enable floats a pending read at once
    step(1'b1, 1'b1, 1'b1, 1'b0, '1, 6'd31, "R7", 1'b1);
    step(1'b1, 1'b1, 1'b1, 1'b0, '1, 6'd32, "R7", 1'b1);
    idle2();

    // R8: stalls around reads and writes with junk on the inputs
    step(1'b1, 1'b1, 1'b1, 1'b0, '1, 6'd3, "R8");
    step(1'b1, 1'b1, 1'b1, 1'b1, '0, 6'd3, "R8");
    for (int k = 0; k < 3; k++) stall("R8");
    step(1'b1, 1'b1, 1'b1, 1'b0, '1, 6'd3, "R8");
    stall("R8");
    step(1'b1, 1'b1, 1'b0, 1'b0, '1, 6'd0, "R8");
    stall("R8"); stall("R8");
    idle2(); idle2();

    // mixed random traffic on a small window to provoke hazards
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 100;
      if (r < 10) stall("R8");
      else if (r < 50)
        step(1'b1, 1'b1, 1'b1, 1'($urandom), LANES'($urandom), ADDR_W'(40 + $urandom % 8), "R1");
      else if (r < 85)
        step(1'b1, 1'b0, 1'b1, 1'($urandom), LANES'($urandom), ADDR_W'($urandom), "R1");
      else
        step(1'b1, 1'b1, 1'b0, 1'($urandom), LANES'($urandom), ADDR_W'($urandom), "R6");
    end
    idle2(); idle2();
    finishRun();
  end
endmodule